// File: doc/BRIEF.md
# Cascaded Interrupt Controller Pair with Poll and Acknowledge

This block joins two 8-line priority interrupt controllers into one 16-number interrupt source. The second controller (the slave) has its pending output wired into line 2 of the first (the master). Each controller keeps a request register, an in-service register, a mask register and an edge/level control register. The master's pending state drives the block's interrupt output. Software reaches the registers through a small address-decoded byte bus.

Two paths return the number of the winning interrupt and retire it in the same cycle. The first is a poll read: a command arms a controller, and its next register read returns the winning level instead of a register value. The second is a single acknowledge strobe that walks the cascade. It resolves the master first and, when the master's winner is line 2, continues into the slave and adds 8 to the slave's level. Each path clears the request and in-service bits of the level it returns. When a path finds nothing pending it returns 7.

Top module: `pic_cascade_pair`

## Requirements
- R1: After a synchronous active-low reset, every request, in-service, mask and edge/level register is 0, poll is disarmed, the read selector points at the request register, and `int_out`, `bus_rdata` and `ack_num` are 0.
- R2: The master answers at byte addresses 0x20 (command/status) and 0x21 (mask). The slave answers at 0xA0 and 0xA1. The master edge/level register is at 0x4D0 and the slave's is at 0x4D1. A write to any other address changes no register, and a read of any other address returns 0.
- R3: A write to an edge/level register stores the data ANDed with a fixed mask: 0xF8 for the master and 0xDE for the slave. A read returns the stored value.
- R4: An edge/level bit of 0 makes its line edge-triggered: a 0-to-1 change sets the request bit, and the bit stays set after the line falls. A bit of 1 makes the request bit follow the line level.
- R5: A controller's pending level is the lowest-numbered request bit that is not masked, provided it is lower than the lowest-numbered in-service bit. `int_out` is high while the master has a pending level.
- R6: A read at the odd address returns the mask, and a write there loads it. A read at the even address returns the in-service register when the selector is 1 and the request register when it is 0. A command byte with bits[4:3]=01 and bit1=1 loads the selector from bit0.
- R7: A command byte with bits[4:3]=00 and bits[7:5]=010 sets the in-service bit numbered by bits[2:0].
- R8: A command byte with bits[4:3]=01 and bit2=1 arms poll. The next read at either address of that controller returns the poll result instead of a register and disarms poll, so the read after it returns a register again.
- R9: A poll read that finds a pending level returns that level and clears its request and in-service bits. A poll read on the slave also clears bit 2 of the master's request and in-service registers.
- R10: A poll read that finds nothing pending returns 7 and changes no request or in-service bit.
- R11: On `ack_req`, when the master's pending level is not 2, `ack_num` becomes that level, the master bit is cleared, and the slave is left untouched.
- R12: Master line 2 is the slave's pending output ORed with external line 2, and it is edge-triggered. On `ack_req`, when the master's pending level is 2, the slave is poll-read as well: `ack_num` becomes 8 plus the slave level, and both the slave's bit and the master's bit 2 are cleared.
- R13: On `ack_req`, `ack_num` becomes 15 when the master's winner is 2 but the slave has nothing pending, and 7 when the master has nothing pending.
- R14: Every `ack_req` sets the master's read selector to the in-service register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_lines | input | 16 | Interrupt lines; bits 7:0 feed the master, bits 15:8 feed the slave |
| bus_addr | input | 16 | Byte address of a register access |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_rd | input | 1 | Read strobe, one cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, registered, held until the next read |
| ack_req | input | 1 | Interrupt acknowledge strobe, one cycle |
| ack_num | output | 4 | Acknowledged interrupt number, registered, held until the next acknowledge |
| int_out | output | 1 | High while the master has a pending level |

## Verification
A read or acknowledge strobe on cycle k puts its result on `bus_rdata` or `ack_num` after the clock edge that ends cycle k. That same edge retires the request and in-service bits. The bench raises a strobe on a falling edge and samples on the following falling edge. An edge on an external line reaches a request register at the next rising edge, and `int_out` follows combinationally from the registers. A slave request needs one more edge to reach master line 2, so the bench waits three cycles after any line pulse before it reads or acknowledges. Each check that a bit was retired, or that a controller was left untouched, reads the register back over the bus after the operation.

// File: rtl/pic_pkg.sv
// Package: shared constants, types and helpers for the cascaded controller pair.
// Assumes 8 lines per controller and byte-wide register data.
package pic_pkg;
    localparam int LINES        = 8;
    localparam int LVL_W        = $clog2(LINES);
    localparam int NUM_W        = LVL_W + 1;
    localparam int CASCADE_LINE = 2;

    typedef logic [LINES-1:0] vec_t;
    typedef logic [LVL_W-1:0] lvl_t;
    typedef logic [NUM_W-1:0] num_t;

    // Level returned when nothing is pending.
    localparam lvl_t IDLE_LVL = lvl_t'(LINES - 1);

    // Command byte fields.
    localparam logic [1:0] KIND_OPT  = 2'b01;
    localparam logic [1:0] KIND_PLAIN = 2'b00;
    localparam logic [2:0] OP_MARK    = 3'b010;

    // Register window inside a decoded range.
    typedef enum logic [1:0] {
        WIN_CMD  = 2'd0,
        WIN_MASK = 2'd1,
        WIN_CTRL = 2'd2
    } win_e;

    typedef struct packed {
        logic hit;
        logic slave;
        win_e win;
    } dec_t;

    // One-hot vector for a level number.
    function automatic vec_t lvl_bit(input lvl_t l);
        return vec_t'(1) << l;
    endfunction
endpackage

// File: rtl/pic_addr_dec.sv
// Module: maps a byte address onto a controller and register window.
// Assumes each controller occupies an aligned two-byte window and each
// edge/level register has a single byte address.
module pic_addr_dec
    import pic_pkg::*;
#(
    parameter logic [15:0] MST_BASE = 16'h0020,
    parameter logic [15:0] SLV_BASE = 16'h00A0,
    parameter logic [15:0] MST_CTRL = 16'h04D0,
    parameter logic [15:0] SLV_CTRL = 16'h04D1
) (
    input  logic [15:0] addr,
    output dec_t        dec
);
    logic [15:0] pair_addr;

    assign pair_addr = {addr[15:1], 1'b0};

    // Compare the address against the four windows.
    always_comb begin
        dec = '{hit: 1'b0, slave: 1'b0, win: WIN_CMD};
        if (pair_addr == MST_BASE) begin
            dec.hit = 1'b1;
            dec.win = addr[0] ? WIN_MASK : WIN_CMD;
        end else if (pair_addr == SLV_BASE) begin
            dec.hit   = 1'b1;
            dec.slave = 1'b1;
            dec.win   = addr[0] ? WIN_MASK : WIN_CMD;
        end else if (addr == MST_CTRL) begin
            dec.hit = 1'b1;
            dec.win = WIN_CTRL;
        end else if (addr == SLV_CTRL) begin
            dec.hit   = 1'b1;
            dec.slave = 1'b1;
            dec.win   = WIN_CTRL;
        end
    end
endmodule

// File: rtl/pic_prio.sv
// Module: fixed-priority resolver for one controller.
// Line 0 ranks highest. A request wins only if it ranks above every
// level that is already in service.
module pic_prio
    import pic_pkg::*;
(
    input  vec_t irr,
    input  vec_t imr,
    input  vec_t isr,
    output logic valid,
    output lvl_t lvl
);
    logic req_hit;
    logic svc_hit;
    lvl_t req_lvl;
    lvl_t svc_lvl;
    vec_t live;

    assign live = irr & ~imr;

    // Find the lowest-numbered live request and the lowest in-service level.
    always_comb begin
        req_hit = 1'b0;
        svc_hit = 1'b0;
        req_lvl = '0;
        svc_lvl = '0;
        for (int i = LINES - 1; i >= 0; i--) begin
            if (live[i]) begin
                req_hit = 1'b1;
                req_lvl = lvl_t'(i);
            end
            if (isr[i]) begin
                svc_hit = 1'b1;
                svc_lvl = lvl_t'(i);
            end
        end
    end

    assign valid = req_hit && (!svc_hit || (req_lvl < svc_lvl));
    assign lvl   = req_lvl;
endmodule

// File: rtl/pic_unit.sv
// Module: state of one 8-line controller (request, in-service, mask,
// edge/level, read selector and poll flag) plus its resolver.
// Assumes the parent sends one clear vector per cycle that covers
// every retirement source, and that poll disarm has priority over arm.
module pic_unit
    import pic_pkg::*;
#(
    parameter vec_t CTRL_MASK = 8'hF8
) (
    input  logic clk,
    input  logic rst_n,
    input  vec_t lines,
    input  logic wr_cmd,
    input  logic wr_mask,
    input  logic wr_ctrl,
    input  logic [7:0] wdata,
    input  logic poll_done,
    input  vec_t clr_vec,
    input  logic force_isr_sel,
    output vec_t irr,
    output vec_t isr,
    output vec_t imr,
    output vec_t ctrl,
    output logic rr_sel,
    output logic poll_armed,
    output logic pend_valid,
    output lvl_t pend_lvl
);
    vec_t last_q;
    vec_t irr_q;
    vec_t isr_q;
    vec_t imr_q;
    vec_t ctrl_q;
    logic rr_q;
    logic poll_q;
    logic is_opt;
    logic is_mark;
    vec_t rise;
    vec_t mark_vec;

    assign is_opt   = (wdata[4:3] == KIND_OPT);
    assign is_mark  = (wdata[4:3] == KIND_PLAIN) && (wdata[7:5] == OP_MARK);
    assign rise     = lines & ~last_q;
    assign mark_vec = (wr_cmd && is_mark) ? lvl_bit(wdata[LVL_W-1:0]) : '0;

    // Remember line levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) last_q <= '0;
        else        last_q <= lines;
    end

    // Request bits: follow the line in level mode, latch rising edges otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) irr_q <= '0;
        else        irr_q <= ((ctrl_q & lines) | (~ctrl_q & (irr_q | rise))) & ~clr_vec;
    end

    // In-service bits: set by the mark command, cleared by retirement.
    always_ff @(posedge clk) begin
        if (!rst_n) isr_q <= '0;
        else        isr_q <= (isr_q | mark_vec) & ~clr_vec;
    end

    // Mask register load.
    always_ff @(posedge clk) begin
        if (!rst_n)       imr_q <= '0;
        else if (wr_mask) imr_q <= wdata;
    end

    // Edge/level register load through the fixed writable mask.
    always_ff @(posedge clk) begin
        if (!rst_n)       ctrl_q <= '0;
        else if (wr_ctrl) ctrl_q <= wdata & CTRL_MASK;
    end

    // Read selector: loaded by command, forced to in-service by acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n)                         rr_q <= 1'b0;
        else if (force_isr_sel)             rr_q <= 1'b1;
        else if (wr_cmd && is_opt && wdata[1]) rr_q <= wdata[0];
    end

    // Poll flag: armed by command, disarmed by the poll read.
    always_ff @(posedge clk) begin
        if (!rst_n)                         poll_q <= 1'b0;
        else if (poll_done)                 poll_q <= 1'b0;
        else if (wr_cmd && is_opt && wdata[2]) poll_q <= 1'b1;
    end

    pic_prio u_prio (
        .irr   (irr_q),
        .imr   (imr_q),
        .isr   (isr_q),
        .valid (pend_valid),
        .lvl   (pend_lvl)
    );

    assign irr        = irr_q;
    assign isr        = isr_q;
    assign imr        = imr_q;
    assign ctrl       = ctrl_q;
    assign rr_sel     = rr_q;
    assign poll_armed = poll_q;
endmodule

// File: rtl/pic_cascade_pair.sv
// Module: master and slave controllers, slave cascaded on master line 2.
// Handles register access, poll reads and the cascaded acknowledge.
// Assumes strobes last one cycle. A read and an acknowledge in the same
// cycle are both served from the state before that edge.
module pic_cascade_pair
    import pic_pkg::*;
#(
    parameter logic [15:0] MST_BASE  = 16'h0020,
    parameter logic [15:0] SLV_BASE  = 16'h00A0,
    parameter logic [15:0] MST_CTRL  = 16'h04D0,
    parameter logic [15:0] SLV_CTRL  = 16'h04D1,
    parameter logic [7:0]  MST_CMASK = 8'hF8,
    parameter logic [7:0]  SLV_CMASK = 8'hDE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2*LINES-1:0] irq_lines,
    input  logic [15:0]       bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic              ack_req,
    output logic [NUM_W-1:0]  ack_num,
    output logic              int_out
);
    dec_t dec;
    vec_t m_lines, s_lines;
    vec_t m_irr, m_isr, m_imr, m_ctrl;
    vec_t s_irr, s_isr, s_imr, s_ctrl;
    logic m_rr_sel, s_rr_sel, m_poll_armed, s_poll_armed;
    logic m_pv, s_pv;
    lvl_t m_lvl, s_lvl;
    logic m_sel, s_sel;
    logic m_wr_cmd, m_wr_mask, m_wr_ctrl;
    logic s_wr_cmd, s_wr_mask, s_wr_ctrl;
    logic m_poll_rd, s_poll_rd;
    vec_t m_clr, s_clr;
    lvl_t m_poll_val, s_poll_val;
    num_t ack_val;
    logic [7:0] rd_next;
    logic [7:0] rdata_q;
    num_t ack_q;

    pic_addr_dec #(
        .MST_BASE (MST_BASE),
        .SLV_BASE (SLV_BASE),
        .MST_CTRL (MST_CTRL),
        .SLV_CTRL (SLV_CTRL)
    ) u_dec (
        .addr (bus_addr),
        .dec  (dec)
    );

    // Route external lines; master cascade line also takes the slave output.
    for (genvar g = 0; g < LINES; g++) begin : g_lines
        if (g == CASCADE_LINE) begin : g_casc
            assign m_lines[g] = irq_lines[g] | s_pv;
        end else begin : g_plain
            assign m_lines[g] = irq_lines[g];
        end
        assign s_lines[g] = irq_lines[LINES + g];
    end

    assign m_sel     = dec.hit && !dec.slave;
    assign s_sel     = dec.hit &&  dec.slave;
    assign m_wr_cmd  = bus_wr && m_sel && (dec.win == WIN_CMD);
    assign m_wr_mask = bus_wr && m_sel && (dec.win == WIN_MASK);
    assign m_wr_ctrl = bus_wr && m_sel && (dec.win == WIN_CTRL);
    assign s_wr_cmd  = bus_wr && s_sel && (dec.win == WIN_CMD);
    assign s_wr_mask = bus_wr && s_sel && (dec.win == WIN_MASK);
    assign s_wr_ctrl = bus_wr && s_sel && (dec.win == WIN_CTRL);
    assign m_poll_rd = bus_rd && m_sel && (dec.win != WIN_CTRL) && m_poll_armed;
    assign s_poll_rd = bus_rd && s_sel && (dec.win != WIN_CTRL) && s_poll_armed;
    assign m_poll_val = m_pv ? m_lvl : IDLE_LVL;
    assign s_poll_val = s_pv ? s_lvl : IDLE_LVL;

    // Build the retirement vectors from poll reads and the acknowledge.
    always_comb begin
        m_clr = '0;
        s_clr = '0;
        if (m_poll_rd && m_pv) m_clr = m_clr | lvl_bit(m_lvl);
        if (s_poll_rd && s_pv) begin
            s_clr = s_clr | lvl_bit(s_lvl);
            m_clr = m_clr | lvl_bit(lvl_t'(CASCADE_LINE));
        end
        if (ack_req && m_pv) begin
            m_clr = m_clr | lvl_bit(m_lvl);
            if ((m_lvl == lvl_t'(CASCADE_LINE)) && s_pv) begin
                s_clr = s_clr | lvl_bit(s_lvl);
            end
        end
    end

    // Acknowledged number: master level, or 8 plus the slave poll result.
    always_comb begin
        if (!m_pv)                              ack_val = {1'b0, IDLE_LVL};
        else if (m_lvl != lvl_t'(CASCADE_LINE)) ack_val = {1'b0, m_lvl};
        else                                    ack_val = {1'b1, s_poll_val};
    end

    // Select the read data for the addressed register or poll result.
    always_comb begin
        rd_next = '0;
        if (dec.hit) begin
            if (dec.win == WIN_CTRL)     rd_next = dec.slave ? s_ctrl : m_ctrl;
            else if (dec.slave) begin
                if (s_poll_armed)          rd_next = 8'(s_poll_val);
                else if (dec.win == WIN_MASK) rd_next = s_imr;
                else                       rd_next = s_rr_sel ? s_isr : s_irr;
            end else begin
                if (m_poll_armed)          rd_next = 8'(m_poll_val);
                else if (dec.win == WIN_MASK) rd_next = m_imr;
                else                       rd_next = m_rr_sel ? m_isr : m_irr;
            end
        end
    end

    // Hold read data until the next read.
    always_ff @(posedge clk) begin
        if (!rst_n)      rdata_q <= '0;
        else if (bus_rd) rdata_q <= rd_next;
    end

    // Hold the acknowledged number until the next acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n)       ack_q <= '0;
        else if (ack_req) ack_q <= ack_val;
    end

    pic_unit #(.CTRL_MASK (MST_CMASK)) u_mst (
        .clk           (clk),
        .rst_n         (rst_n),
        .lines         (m_lines),
        .wr_cmd        (m_wr_cmd),
        .wr_mask       (m_wr_mask),
        .wr_ctrl       (m_wr_ctrl),
        .wdata         (bus_wdata),
        .poll_done     (m_poll_rd),
        .clr_vec       (m_clr),
        .force_isr_sel (ack_req),
        .irr           (m_irr),
        .isr           (m_isr),
        .imr           (m_imr),
        .ctrl          (m_ctrl),
        .rr_sel        (m_rr_sel),
        .poll_armed    (m_poll_armed),
        .pend_valid    (m_pv),
        .pend_lvl      (m_lvl)
    );

    pic_unit #(.CTRL_MASK (SLV_CMASK)) u_slv (
        .clk           (clk),
        .rst_n         (rst_n),
        .lines         (s_lines),
        .wr_cmd        (s_wr_cmd),
        .wr_mask       (s_wr_mask),
        .wr_ctrl       (s_wr_ctrl),
        .wdata         (bus_wdata),
        .poll_done     (s_poll_rd),
        .clr_vec       (s_clr),
        .force_isr_sel (1'b0),
        .irr           (s_irr),
        .isr           (s_isr),
        .imr           (s_imr),
        .ctrl          (s_ctrl),
        .rr_sel        (s_rr_sel),
        .poll_armed    (s_poll_armed),
        .pend_valid    (s_pv),
        .pend_lvl      (s_lvl)
    );

    assign bus_rdata = rdata_q;
    assign ack_num   = ack_q;
    assign int_out   = m_pv;
endmodule

// File: rtl/pic_cascade_chk.sv
// Module: property checker for the cascaded pair, attached by bind.
// Observes ports and the poll, selector and edge/level state of both units.
module pic_cascade_chk #(
    parameter logic [15:0] MST_BASE = 16'h0020,
    parameter logic [15:0] SLV_BASE = 16'h00A0,
    parameter logic [15:0] MST_CTRL = 16'h04D0,
    parameter logic [15:0] SLV_CTRL = 16'h04D1
) (
    input logic        clk,
    input logic        rst_n,
    input logic [15:0] bus_addr,
    input logic        bus_wr,
    input logic        bus_rd,
    input logic [7:0]  bus_wdata,
    input logic [7:0]  bus_rdata,
    input logic        ack_req,
    input logic [3:0]  ack_num,
    input logic        int_out,
    input logic [7:0]  m_ctrl,
    input logic [7:0]  s_ctrl,
    input logic        m_poll_armed,
    input logic        m_rr_sel
);
    logic addr_known;
    logic addr_mst;

    assign addr_mst   = ({bus_addr[15:1], 1'b0} == MST_BASE);
    assign addr_known = addr_mst || ({bus_addr[15:1], 1'b0} == SLV_BASE)
                        || (bus_addr == MST_CTRL) || (bus_addr == SLV_CTRL);

    a_r1_reset_outputs: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (bus_rdata == 8'h00 && ack_num == 4'h0 && !int_out));

    a_r2_miss_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !addr_known) |=> (bus_rdata == 8'h00));

    a_r3_master_ctrl_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == MST_CTRL) |=> (m_ctrl == ($past(bus_wdata) & 8'hF8)));

    a_r3_slave_ctrl_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == SLV_CTRL) |=> (s_ctrl == ($past(bus_wdata) & 8'hDE)));

    a_r8_poll_disarms: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && addr_mst && m_poll_armed) |=> !m_poll_armed);

    a_r12_never_two: assert property (@(posedge clk) disable iff (!rst_n)
        ack_req |=> (ack_num != 4'd2));

    a_r13_idle_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_req && !int_out) |=> (ack_num == 4'd7));

    a_r14_ack_selects_isr: assert property (@(posedge clk) disable iff (!rst_n)
        ack_req |=> m_rr_sel);
endmodule

bind pic_cascade_pair pic_cascade_chk #(
    .MST_BASE (MST_BASE),
    .SLV_BASE (SLV_BASE),
    .MST_CTRL (MST_CTRL),
    .SLV_CTRL (SLV_CTRL)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_addr     (bus_addr),
    .bus_wr       (bus_wr),
    .bus_rd       (bus_rd),
    .bus_wdata    (bus_wdata),
    .bus_rdata    (bus_rdata),
    .ack_req      (ack_req),
    .ack_num      (ack_num),
    .int_out      (int_out),
    .m_ctrl       (m_ctrl),
    .s_ctrl       (s_ctrl),
    .m_poll_armed (m_poll_armed),
    .m_rr_sel     (m_rr_sel)
);

// File: tb/pic_cascade_pair_bench.sv
// Directed bench: one task per scenario, each checking its own results.
module pic_cascade_pair_bench;
    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] irq_lines = '0;
    logic [15:0] bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        ack_req = 1'b0;
    logic [3:0]  ack_num;
    logic        int_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    pic_cascade_pair u_pic_cascade_pair (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq_lines (irq_lines),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .ack_req   (ack_req),
        .ack_num   (ack_num),
        .int_out   (int_out)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        irq_lines = '0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic bus_write(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [15:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic do_ack(output logic [3:0] n);
        @(negedge clk);
        ack_req = 1'b1;
        @(negedge clk);
        ack_req = 1'b0;
        n = ack_num;
    endtask

    task automatic pulse_line(input int idx);
        @(negedge clk);
        irq_lines[idx] = 1'b1;
        @(negedge clk);
        irq_lines[idx] = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_reset_state();
        logic [7:0] d;
        do_reset();
        check("R1 int_out", {7'd0, int_out}, 8'h00);
        check("R1 ack_num", {4'd0, ack_num}, 8'h00);
        check("R1 rdata", bus_rdata, 8'h00);
        bus_read(16'h0020, d); check("R1 master request", d, 8'h00);
        bus_read(16'h00A1, d); check("R1 slave mask", d, 8'h00);
        bus_read(16'h04D0, d); check("R1 master edge/level", d, 8'h00);
    endtask

    task automatic t_decode();
        logic [7:0] d;
        do_reset();
        bus_write(16'h0022, 8'hFF);
        bus_read(16'h0021, d); check("R2 stray write leaves master mask", d, 8'h00);
        bus_read(16'h0022, d); check("R2 stray read is zero", d, 8'h00);
        bus_write(16'h00A1, 8'h5A);
        bus_read(16'h00A1, d); check("R2 slave mask window", d, 8'h5A);
        bus_read(16'h0021, d); check("R2 master mask separate", d, 8'h00);
        bus_write(16'h04D2, 8'hFF);
        bus_read(16'h04D0, d); check("R2 stray write leaves edge/level", d, 8'h00);
    endtask

    task automatic t_ctrl_mask();
        logic [7:0] d;
        do_reset();
        bus_write(16'h04D0, 8'hFF);
        bus_read(16'h04D0, d); check("R3 master mask F8", d, 8'hF8);
        bus_write(16'h04D1, 8'hFF);
        bus_read(16'h04D1, d); check("R3 slave mask DE", d, 8'hDE);
        bus_write(16'h04D1, 8'h21);
        bus_read(16'h04D1, d); check("R3 slave masked bits dropped", d, 8'h00);
    endtask

    task automatic t_edge_level();
        logic [7:0] d;
        do_reset();
        pulse_line(3);
        bus_read(16'h0020, d); check("R4 edge latched", d, 8'h08);
        bus_write(16'h04D0, 8'h10);
        @(negedge clk); irq_lines[4] = 1'b1;
        repeat (2) @(negedge clk);
        bus_read(16'h0020, d); check("R4 level high", d, 8'h18);
        irq_lines[4] = 1'b0;
        repeat (2) @(negedge clk);
        bus_read(16'h0020, d); check("R4 level follows low", d, 8'h08);
    endtask

    task automatic t_priority_mark();
        logic [7:0] d;
        do_reset();
        pulse_line(5);
        check("R5 int_out on request", {7'd0, int_out}, 8'h01);
        bus_write(16'h0021, 8'h20);
        check("R5 masked line quiet", {7'd0, int_out}, 8'h00);
        bus_write(16'h0021, 8'h00);
        bus_write(16'h0020, 8'h43);
        check("R5 in-service 3 blocks 5", {7'd0, int_out}, 8'h00);
        bus_write(16'h0020, 8'h0B);
        bus_read(16'h0020, d); check("R7 mark sets in-service 3", d, 8'h08);
        bus_write(16'h0020, 8'h0A);
        bus_read(16'h0020, d); check("R6 selector back to request", d, 8'h20);
        bus_read(16'h0021, d); check("R6 odd address is mask", d, 8'h00);
        pulse_line(1);
        check("R5 line 1 outranks in-service 3", {7'd0, int_out}, 8'h01);
    endtask

    task automatic t_poll_master();
        logic [7:0] d;
        do_reset();
        pulse_line(6);
        pulse_line(3);
        bus_write(16'h0020, 8'h0C);
        bus_read(16'h0021, d); check("R9 poll returns level 3", d, 8'h03);
        bus_read(16'h0020, d); check("R8 poll disarmed, request left", d, 8'h40);
        bus_write(16'h0020, 8'h0C);
        bus_read(16'h0020, d); check("R9 second poll level 6", d, 8'h06);
        bus_read(16'h0020, d); check("R9 request cleared", d, 8'h00);
    endtask

    task automatic t_poll_empty();
        logic [7:0] d;
        do_reset();
        bus_write(16'h0020, 8'h42);
        pulse_line(5);
        check("R10 blocked request", {7'd0, int_out}, 8'h00);
        bus_write(16'h0020, 8'h0C);
        bus_read(16'h0020, d); check("R10 empty poll returns 7", d, 8'h07);
        bus_read(16'h0020, d); check("R10 request kept", d, 8'h20);
        bus_write(16'h0020, 8'h0B);
        bus_read(16'h0020, d); check("R10 in-service kept", d, 8'h04);
    endtask

    task automatic t_poll_slave();
        logic [7:0] d;
        do_reset();
        pulse_line(10);
        bus_write(16'h0020, 8'h42);
        bus_write(16'h0020, 8'h0A);
        bus_read(16'h0020, d); check("R12 cascade line latched", d, 8'h04);
        bus_write(16'h00A0, 8'h0C);
        bus_read(16'h00A1, d); check("R9 slave poll level 2", d, 8'h02);
        bus_read(16'h0020, d); check("R9 master request 2 cleared", d, 8'h00);
        bus_write(16'h0020, 8'h0B);
        bus_read(16'h0020, d); check("R9 master in-service 2 cleared", d, 8'h00);
        bus_read(16'h00A0, d); check("R9 slave request cleared", d, 8'h00);
    endtask

    task automatic t_ack_master();
        logic [7:0] d;
        logic [3:0] n;
        do_reset();
        pulse_line(1);
        pulse_line(11);
        do_ack(n); check("R11 ack master level 1", {4'd0, n}, 8'h01);
        bus_read(16'h00A0, d); check("R11 slave untouched", d, 8'h08);
        bus_read(16'h0020, d); check("R14 selector forced to in-service", d, 8'h00);
        bus_write(16'h0020, 8'h0A);
        bus_read(16'h0020, d); check("R11 master keeps line 2", d, 8'h04);
    endtask

    task automatic t_ack_cascade();
        logic [7:0] d;
        logic [3:0] n;
        do_reset();
        pulse_line(11);
        do_ack(n); check("R12 ack through slave gives 11", {4'd0, n}, 8'h0B);
        check("R12 no pending after ack", {7'd0, int_out}, 8'h00);
        bus_read(16'h00A0, d); check("R12 slave bit cleared", d, 8'h00);
        bus_write(16'h0020, 8'h0A);
        bus_read(16'h0020, d); check("R12 master bit 2 cleared", d, 8'h00);
    endtask

    task automatic t_ack_fallback();
        logic [7:0] d;
        logic [3:0] n;
        do_reset();
        pulse_line(9);
        bus_write(16'h00A1, 8'h02);
        do_ack(n); check("R13 empty slave gives 15", {4'd0, n}, 8'h0F);
        bus_write(16'h0020, 8'h0A);
        bus_read(16'h0020, d); check("R13 master line 2 retired", d, 8'h00);
        do_ack(n); check("R13 idle ack gives 7", {4'd0, n}, 8'h07);
    endtask

    initial begin
        t_reset_state();
        t_decode();
        t_ctrl_mask();
        t_edge_level();
        t_priority_mark();
        t_poll_master();
        t_poll_empty();
        t_poll_slave();
        t_ack_master();
        t_ack_cascade();
        t_ack_fallback();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule